// File: doc/BRIEF.md
# Register-Driven SPI Shift Engine

This block is an SPI host that software drives through a small 32-bit register port. Software sets a clock divider, loads up to 32 bits of transmit data and then writes a single shift-control word. That word carries a start bit, a chip-select mask, a bit count and a flag that says whether chip select is released at the end. The engine clocks the bits out on the serial data-out pin with the most significant active bit first. It samples the serial data-in pin on every rising clock edge and stores the received word in a readable register. When the last bit is done, the engine clears the start bit.

Chip select works at the level of a burst. A burst whose release flag is clear leaves its chip select asserted after it ends. A longer transaction can therefore be built from several bursts of up to 32 bits each. The line is released only when a burst marked for release completes. An I/O control register sets the levels the pins rest at while no burst is running. Reset leaves every chip select high and both data-out and the serial clock low. The clock runs in mode 0: it idles low, data-in is sampled on the rising edge and data-out changes after the falling edge.

Top module: `spi_shift_host`

## Requirements
- R1: After reset all three chip-select outputs are high, the serial clock and data-out are low, the I/O control register (offset 0x08) reads 0x00070000, the start bit 31 of shift control (offset 0x14) reads 0 and data-in (offset 0x18) reads 0.
- R2: A burst starts when shift control is written with bit 31 set, bit 0 of the enable register (offset 0x00) is 1, the engine is idle and the count field bits [5:0] is between 1 and 32. Bit 31 then reads 1 for exactly 2*(div+1)*count clock cycles and reads 0 afterwards.
- R3: During a burst every bit has a low half of div+1 clock cycles followed by a high half of div+1 cycles, where div is control register (offset 0x04) bits [5:0]. The serial clock is low whenever no burst is running.
- R4: Data-out presents bit count-1 of the data-out register (offset 0x10) first and then each lower bit in turn. A new bit appears when the serial clock falls, and the value holds through each whole bit period.
- R5: Data-in is sampled at each rising serial clock edge. When the burst completes, data-in (offset 0x18) holds the received bits with the first one in bit count-1 and zeros above the active count. The register keeps that value until the next burst completes.
- R6: Shift-control bits [30:28] select chip-select lines 2..0, and a selected line goes low from the start of the burst. If bit 26 is 1, the selected lines return to their idle levels in the same cycle that bit 31 clears. If bit 26 is 0, they stay low until a burst with bit 26 set completes.
- R7: While bit 31 reads 1, writes to data-out (0x10), control (0x04) and shift control (0x14) are ignored. This includes the readback of the shift-control count field.
- R8: A start with count 0 or above 32 produces no serial clock edge and leaves bit 31 reading 0. Its chip-select mask and release flag take effect at once, and data-in is left unchanged.
- R9: I/O control bits [18:16] give the idle levels of chip-select lines 2..0 and bit 0 gives the idle level of data-out. A chip-select line that is not held by a burst shows its idle level.
- R10: While enable bit 0 is 0, a shift-control write with bit 31 set starts nothing. No serial clock edge is produced and bit 31 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 3 | Active-low chip selects |

## Verification
The assertions assume three things. First, the divider stays fixed for the whole burst. Second, data-in changes only away from the rising serial clock edge, as a mode-0 device does when it updates after the falling edge. Third, the register port is driven with single-cycle write strobes that are stable around each clock edge. The stimulus drives every register write as a one-cycle strobe set up on the falling system clock edge. It changes the serial input only on falling system clock edges, and only when the bit index of a burst advances, so the value is steady when the engine samples it. Some stimulus tries to change the divider or the transmit data in the middle of a burst. The reference model and the pin comparison both expect those writes to have no effect.

// File: rtl/spi_sh_pkg.sv
package spi_sh_pkg;
  // register byte offsets
  localparam int unsigned OFS_FUNC  = 32'h00;
  localparam int unsigned OFS_CTRL  = 32'h04;
  localparam int unsigned OFS_IOC   = 32'h08;
  localparam int unsigned OFS_TXD   = 32'h10;
  localparam int unsigned OFS_SHIFT = 32'h14;
  localparam int unsigned OFS_RXD   = 32'h18;

  // shift-control field positions
  localparam int unsigned START_BIT = 31;
  localparam int unsigned CSEL_LSB  = 28;
  localparam int unsigned TERM_BIT  = 26;

  // I/O control field positions
  localparam int unsigned IOC_CS_LSB   = 16;
  localparam int unsigned IOC_MOSI_BIT = 0;

  typedef enum logic {
    ENG_IDLE  = 1'b0,
    ENG_SHIFT = 1'b1
  } eng_state_e;
endpackage

// File: rtl/spi_sh_rst_sync.sv
module spi_sh_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/spi_sh_regs.sv
module spi_sh_regs
  import spi_sh_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DIV_W  = 6,
  parameter int unsigned CNT_W  = 6,
  parameter int unsigned NUM_CS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              busy_i,
  input  logic              done_i,
  input  logic [DATA_W-1:0] rx_i,
  output logic [DIV_W-1:0]  div_o,
  output logic [DATA_W-1:0] tx_o,
  output logic [NUM_CS-1:0] cs_idle_o,
  output logic              mosi_idle_o,
  output logic              start_any_o,
  output logic              start_shift_o,
  output logic              start_imm_o,
  output logic [NUM_CS-1:0] sel_o,
  output logic              term_o,
  output logic [CNT_W-1:0]  count_o
);
  localparam logic [CNT_W:0]  FULL_CNT = (CNT_W+1)'(DATA_W);
  localparam logic [DATA_W-1:0] IOC_RST =
    DATA_W'(((1 << NUM_CS) - 1) << IOC_CS_LSB);

  logic              en_q;
  logic [DIV_W-1:0]  div_q;
  logic [NUM_CS-1:0] csidle_q;
  logic              mosiidle_q;
  logic [DATA_W-1:0] tx_q;
  logic [DATA_W-1:0] din_q;
  logic [NUM_CS-1:0] cfg_sel_q;
  logic              cfg_term_q;
  logic [CNT_W-1:0]  cfg_cnt_q;

  logic hit_func, hit_ctrl, hit_ioc, hit_txd, hit_shift;
  logic func_we, ctrl_we, ioc_we, txd_we, cfg_we, din_we;
  logic start_req, cnt_ok;
  logic [CNT_W-1:0] wcnt;

  // write decode and clock enables
  always_comb begin
    hit_func  = wr_i && (addr_i == ADDR_W'(OFS_FUNC));
    hit_ctrl  = wr_i && (addr_i == ADDR_W'(OFS_CTRL));
    hit_ioc   = wr_i && (addr_i == ADDR_W'(OFS_IOC));
    hit_txd   = wr_i && (addr_i == ADDR_W'(OFS_TXD));
    hit_shift = wr_i && (addr_i == ADDR_W'(OFS_SHIFT));
    wcnt      = wdata_i[CNT_W-1:0];
    cnt_ok    = (wcnt != '0) && ({1'b0, wcnt} <= FULL_CNT);
    start_req = hit_shift && wdata_i[START_BIT] && en_q && !busy_i;
    func_we   = hit_func;
    ctrl_we   = hit_ctrl && !busy_i;
    ioc_we    = hit_ioc;
    txd_we    = hit_txd && !busy_i;
    cfg_we    = start_req;
    din_we    = done_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q       <= 1'b0;
      div_q      <= '0;
      csidle_q   <= IOC_RST[IOC_CS_LSB +: NUM_CS];
      mosiidle_q <= IOC_RST[IOC_MOSI_BIT];
      tx_q       <= '0;
      din_q      <= '0;
      cfg_sel_q  <= '0;
      cfg_term_q <= 1'b0;
      cfg_cnt_q  <= '0;
    end else begin
      if (func_we) en_q <= wdata_i[0];
      if (ctrl_we) div_q <= wdata_i[DIV_W-1:0];
      if (ioc_we) begin
        csidle_q   <= wdata_i[IOC_CS_LSB +: NUM_CS];
        mosiidle_q <= wdata_i[IOC_MOSI_BIT];
      end
      if (txd_we) tx_q <= wdata_i;
      if (din_we) din_q <= rx_i;
      if (cfg_we) begin
        cfg_sel_q  <= wdata_i[CSEL_LSB +: NUM_CS];
        cfg_term_q <= wdata_i[TERM_BIT];
        cfg_cnt_q  <= wcnt;
      end
    end
  end

  // read mux
  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_W'(OFS_FUNC): rdata_o[0] = en_q;
      ADDR_W'(OFS_CTRL): rdata_o[DIV_W-1:0] = div_q;
      ADDR_W'(OFS_IOC): begin
        rdata_o[IOC_CS_LSB +: NUM_CS] = csidle_q;
        rdata_o[IOC_MOSI_BIT]         = mosiidle_q;
      end
      ADDR_W'(OFS_TXD): rdata_o = tx_q;
      ADDR_W'(OFS_SHIFT): begin
        rdata_o[START_BIT]          = busy_i;
        rdata_o[CSEL_LSB +: NUM_CS] = cfg_sel_q;
        rdata_o[TERM_BIT]           = cfg_term_q;
        rdata_o[CNT_W-1:0]          = cfg_cnt_q;
      end
      ADDR_W'(OFS_RXD): rdata_o = din_q;
      default: rdata_o = '0;
    endcase
  end

  assign div_o         = div_q;
  assign tx_o          = tx_q;
  assign cs_idle_o     = csidle_q;
  assign mosi_idle_o   = mosiidle_q;
  assign start_any_o   = start_req;
  assign start_shift_o = start_req && cnt_ok;
  assign start_imm_o   = start_req && !cnt_ok;
  assign sel_o         = wdata_i[CSEL_LSB +: NUM_CS];
  assign term_o        = wdata_i[TERM_BIT];
  assign count_o       = wcnt;

  // R5: received word only changes at burst completion
  a_r5_din_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(done_i) |-> $stable(din_q));
  // R7: transmit data and divider frozen while busy
  a_r7_tx_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy_i) |-> ($stable(tx_q) && $stable(div_q)));
endmodule

// File: rtl/spi_sh_engine.sv
module spi_sh_engine
  import spi_sh_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DIV_W  = 6,
  parameter int unsigned CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [DATA_W-1:0] tx_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              miso_i,
  input  logic              mosi_idle_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              sclk_o,
  output logic              mosi_o,
  output logic [DATA_W-1:0] rx_o
);
  localparam logic [CNT_W:0] FULL_CNT = (CNT_W+1)'(DATA_W);

  eng_state_e        state_q, state_d;
  logic [DIV_W-1:0]  half_q, half_d;
  logic [CNT_W-1:0]  bits_q, bits_d;
  logic              sclk_q, sclk_d;
  logic [DATA_W-1:0] txsr_q, txsr_d;
  logic [DATA_W-1:0] rx_q, rx_d;
  logic              half_end, last_bit, fall_edge, run_en;
  logic [CNT_W:0]    align;

  always_comb begin
    half_end  = (half_q == '0);
    last_bit  = (bits_q == CNT_W'(1));
    fall_edge = (state_q == ENG_SHIFT) && half_end && sclk_q;
    align     = FULL_CNT - {1'b0, count_i};
    run_en    = start_i || (state_q == ENG_SHIFT);

    state_d = state_q;
    half_d  = half_q;
    bits_d  = bits_q;
    sclk_d  = sclk_q;
    txsr_d  = txsr_q;
    rx_d    = rx_q;

    unique case (state_q)
      ENG_IDLE: begin
        if (start_i) begin
          state_d = ENG_SHIFT;
          half_d  = div_i;
          bits_d  = count_i;
          sclk_d  = 1'b0;
          txsr_d  = tx_i << align;
          rx_d    = '0;
        end
      end
      ENG_SHIFT: begin
        if (!half_end) begin
          half_d = half_q - DIV_W'(1);
        end else begin
          half_d = div_i;
          if (!sclk_q) begin
            sclk_d = 1'b1;
            rx_d   = {rx_q[DATA_W-2:0], miso_i};
          end else begin
            sclk_d = 1'b0;
            bits_d = bits_q - CNT_W'(1);
            txsr_d = {txsr_q[DATA_W-2:0], 1'b0};
            if (last_bit) state_d = ENG_IDLE;
          end
        end
      end
      default: state_d = ENG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ENG_IDLE;
      half_q  <= '0;
      bits_q  <= '0;
      sclk_q  <= 1'b0;
      txsr_q  <= '0;
      rx_q    <= '0;
    end else if (run_en) begin
      state_q <= state_d;
      half_q  <= half_d;
      bits_q  <= bits_d;
      sclk_q  <= sclk_d;
      txsr_q  <= txsr_d;
      rx_q    <= rx_d;
    end
  end

  assign busy_o = (state_q == ENG_SHIFT);
  assign done_o = fall_edge && last_bit;
  assign sclk_o = sclk_q;
  assign mosi_o = busy_o ? txsr_q[DATA_W-1] : mosi_idle_i;
  assign rx_o   = rx_q;

  // R3: clock rests low outside a burst
  a_r3_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !sclk_q);
  // R2: a burst ends only after a high half period
  a_r2_end_after_high: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> $past(sclk_q));
  // R4: data-out holds through the high half
  a_r4_mosi_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_q && $past(sclk_q)) |-> $stable(mosi_o));
  // R3: divider seen by the engine does not move mid-burst
  a_r3_div_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(div_i));
endmodule

// File: rtl/spi_sh_cs.sv
module spi_sh_cs #(
  parameter int unsigned NUM_CS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_any_i,
  input  logic              start_imm_i,
  input  logic              start_shift_i,
  input  logic [NUM_CS-1:0] sel_i,
  input  logic              term_i,
  input  logic              done_i,
  input  logic              busy_i,
  input  logic [NUM_CS-1:0] cs_idle_i,
  output logic [NUM_CS-1:0] cs_n_o
);
  logic [NUM_CS-1:0] act_q, act_d;
  logic              term_q;
  logic              act_we, term_we;

  always_comb begin
    act_we  = start_any_i || (done_i && term_q);
    term_we = start_shift_i;
    if (start_any_i) act_d = (start_imm_i && term_i) ? '0 : sel_i;
    else             act_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= '0;
      term_q <= 1'b0;
    end else begin
      if (act_we)  act_q  <= act_d;
      if (term_we) term_q <= term_i;
    end
  end

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign cs_n_o[i] = act_q[i] ? 1'b0 : cs_idle_i[i];
  end

  // R6: held lines never move in the middle of a burst
  a_r6_act_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && $past(busy_i)) |-> $stable(act_q));
  // R6: a releasing burst frees every line
  a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && term_q) |=> (act_q == '0));
endmodule

// File: rtl/spi_shift_host.sv
module spi_shift_host #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DIV_W  = 6,
  parameter int unsigned CNT_W  = 6,
  parameter int unsigned NUM_CS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic [NUM_CS-1:0] spi_cs_n
);
  logic              rst_s_n;
  logic              busy, done;
  logic [DATA_W-1:0] rx_word, tx_word;
  logic [DIV_W-1:0]  div;
  logic [NUM_CS-1:0] cs_idle, sel;
  logic              mosi_idle, term;
  logic              start_any, start_shift, start_imm;
  logic [CNT_W-1:0]  count;

  spi_sh_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_ni (rst_n),
    .rst_no (rst_s_n)
  );

  spi_sh_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .DIV_W(DIV_W),
    .CNT_W(CNT_W), .NUM_CS(NUM_CS)
  ) u_regs (
    .clk           (clk),
    .rst_n         (rst_s_n),
    .wr_i          (reg_wr),
    .addr_i        (reg_addr),
    .wdata_i       (reg_wdata),
    .rdata_o       (reg_rdata),
    .busy_i        (busy),
    .done_i        (done),
    .rx_i          (rx_word),
    .div_o         (div),
    .tx_o          (tx_word),
    .cs_idle_o     (cs_idle),
    .mosi_idle_o   (mosi_idle),
    .start_any_o   (start_any),
    .start_shift_o (start_shift),
    .start_imm_o   (start_imm),
    .sel_o         (sel),
    .term_o        (term),
    .count_o       (count)
  );

  spi_sh_engine #(.DATA_W(DATA_W), .DIV_W(DIV_W), .CNT_W(CNT_W)) u_eng (
    .clk         (clk),
    .rst_n       (rst_s_n),
    .start_i     (start_shift),
    .count_i     (count),
    .tx_i        (tx_word),
    .div_i       (div),
    .miso_i      (spi_miso),
    .mosi_idle_i (mosi_idle),
    .busy_o      (busy),
    .done_o      (done),
    .sclk_o      (spi_sclk),
    .mosi_o      (spi_mosi),
    .rx_o        (rx_word)
  );

  spi_sh_cs #(.NUM_CS(NUM_CS)) u_cs (
    .clk           (clk),
    .rst_n         (rst_s_n),
    .start_any_i   (start_any),
    .start_imm_i   (start_imm),
    .start_shift_i (start_shift),
    .sel_i         (sel),
    .term_i        (term),
    .done_i        (done),
    .busy_i        (busy),
    .cs_idle_i     (cs_idle),
    .cs_n_o        (spi_cs_n)
  );

  // R8: an out-of-range count never launches the shifter
  a_r8_no_launch: assert property (@(posedge clk) disable iff (!rst_s_n)
    (start_imm && !busy) |=> !busy);
endmodule

// File: tb/tb_spi_shift_host.sv
module tb_spi_shift_host;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [4:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        spi_sclk, spi_mosi, spi_miso;
  logic [2:0]  spi_cs_n;

  always #5 clk = ~clk;

  spi_shift_host dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  int rises = 0;
  logic prev_sclk = 1'b0;

  // reference model state
  bit          m_busy, m_en, m_term, m_idle_mosi;
  int          m_t, m_total, m_c, m_d;
  logic [5:0]  m_div;
  logic [31:0] m_dout, m_tx, m_din, slave;
  logic [2:0]  m_act, m_idle_cs;

  function automatic logic [31:0] mk(int c);
    return (c >= 32) ? 32'hFFFF_FFFF : ((32'd1 << c) - 32'd1);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_en = 0; m_term = 0; m_idle_mosi = 0;
      m_t = 0; m_total = 0; m_c = 1; m_d = 0;
      m_div = '0; m_dout = '0; m_tx = '0; m_din = '0;
      m_act = '0; m_idle_cs = 3'b111;
    end else begin
      bit bo;
      bo = m_busy;
      if (reg_wr) begin
        case (reg_addr)
          5'h00: m_en = reg_wdata[0];
          5'h04: if (!bo) m_div = reg_wdata[5:0];
          5'h08: begin m_idle_cs = reg_wdata[18:16]; m_idle_mosi = reg_wdata[0]; end
          5'h10: if (!bo) m_dout = reg_wdata;
          default: ;
        endcase
      end
      if (bo) begin
        m_t++;
        if (m_t == m_total) begin
          m_busy = 0;
          m_din = slave & mk(m_c);
          if (m_term) m_act = '0;
        end
      end
      if (reg_wr && reg_addr == 5'h14 && reg_wdata[31] && m_en && !bo) begin
        int cnt;
        cnt = int'(reg_wdata[5:0]);
        if (cnt >= 1 && cnt <= 32) begin
          m_busy = 1; m_t = 0; m_c = cnt; m_d = int'(m_div);
          m_total = 2 * (m_d + 1) * cnt;
          m_tx = m_dout; m_term = reg_wdata[26];
          m_act = reg_wdata[30:28];
        end else begin
          m_act = reg_wdata[26] ? 3'b000 : reg_wdata[30:28];
        end
      end
    end
  end

  // per-cycle pin comparison and serial device model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      logic es, em;
      int per, k;
      per = 2 * (m_d + 1);
      k = m_t / per;
      es = m_busy && ((m_t % per) >= (m_d + 1));
      em = m_busy ? m_tx[m_c-1-k] : m_idle_mosi;
      check("R3", {31'd0, spi_sclk}, {31'd0, es}, "sclk");
      check("R4", {31'd0, spi_mosi}, {31'd0, em}, "mosi");
      check("R6", {29'd0, spi_cs_n}, {29'd0, (m_idle_cs & ~m_act)}, "cs_n");
      spi_miso = m_busy ? slave[m_c-1-k] : 1'b0;
      if (spi_sclk && !prev_sclk) rises++;
      prev_sclk = spi_sclk;
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle(output int cyc);
    logic [31:0] v;
    cyc = 0;
    for (int i = 0; i < 20000; i++) begin
      rd(5'h14, v);
      if (!v[31]) break;
      cyc++;
      @(negedge clk);
    end
  endtask

  function automatic logic [31:0] sword(logic [2:0] cs, bit term, int cnt);
    return 32'h8000_0000 | ({29'd0, cs} << 28) | ({31'd0, term} << 26) | (cnt & 32'h3F);
  endfunction

  task automatic burst(int dv, logic [2:0] cs, bit term, int cnt,
                       logic [31:0] tx, logic [31:0] sw);
    int cyc;
    logic [31:0] v;
    wr(5'h04, dv);
    wr(5'h10, tx);
    slave = sw;
    wr(5'h14, sword(cs, term, cnt));
    wait_idle(cyc);
    check("R2", cyc, 2 * (dv + 1) * cnt, "busy cycles");
    rd(5'h18, v);
    check("R5", v, sw & mk(cnt), "data-in");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
    end
  end

  initial begin
    logic [31:0] v;
    int r0;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    spi_miso = 1'b0; slave = '0;
    repeat (3) @(negedge clk);
    check("R1", {29'd0, spi_cs_n}, 32'd7, "reset cs_n");
    check("R1", {31'd0, spi_sclk}, 32'd0, "reset sclk");
    check("R1", {31'd0, spi_mosi}, 32'd0, "reset mosi");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rd(5'h08, v); check("R1", v, 32'h0007_0000, "ioctl reset");
    rd(5'h14, v); check("R1", {31'd0, v[31]}, 32'd0, "start bit reset");
    rd(5'h18, v); check("R1", v, 32'd0, "data-in reset");

    wr(5'h00, 32'd1);
    burst(0, 3'b001, 1, 8, 32'h0000_00A5, 32'h0000_003C);
    check("R6", {29'd0, spi_cs_n}, 32'd7, "released after term");
    burst(2, 3'b010, 0, 16, 32'h0000_1234, 32'h0000_BEEF);
    repeat (3) @(negedge clk);
    check("R6", {29'd0, spi_cs_n}, 32'd5, "held without term");
    burst(0, 3'b010, 1, 24, 32'h00C0_FFEE, 32'h005A_5A5A);
    check("R6", {29'd0, spi_cs_n}, 32'd7, "released by later burst");
    burst(1, 3'b100, 1, 32, 32'hDEAD_BEEF, 32'h1234_5678);
    burst(0, 3'b001, 1, 5, 32'h0000_0015, 32'h0000_000A);

    // R7: writes during a burst are dropped
    wr(5'h04, 32'd3);
    wr(5'h10, 32'h0000_F00D);
    slave = 32'h0000_1357;
    wr(5'h14, sword(3'b001, 1, 16));
    repeat (10) @(negedge clk);
    wr(5'h10, 32'hFFFF_FFFF);
    wr(5'h04, 32'd0);
    wr(5'h14, sword(3'b100, 1, 8));
    begin int c; wait_idle(c); end
    rd(5'h10, v); check("R7", v, 32'h0000_F00D, "data-out kept");
    rd(5'h04, v); check("R7", v, 32'd3, "divider kept");
    rd(5'h18, v); check("R7", v, 32'h0000_1357, "second start dropped");
    rd(5'h14, v); check("R7", {26'd0, v[5:0]}, 32'd16, "count readback kept");

    // R8: zero and oversized counts
    r0 = rises;
    wr(5'h14, sword(3'b001, 0, 0));
    rd(5'h14, v); check("R8", {31'd0, v[31]}, 32'd0, "count 0 not busy");
    check("R8", {29'd0, spi_cs_n}, 32'd6, "count 0 asserts cs");
    wr(5'h14, sword(3'b001, 1, 40));
    rd(5'h14, v); check("R8", {31'd0, v[31]}, 32'd0, "count 40 not busy");
    check("R8", {29'd0, spi_cs_n}, 32'd7, "count 40 releases cs");
    repeat (5) @(negedge clk);
    check("R8", rises, r0, "no sclk edges");
    rd(5'h18, v); check("R8", v, 32'h0000_1357, "data-in unchanged");

    // R9: idle levels
    wr(5'h08, 32'h0005_0001);
    check("R9", {29'd0, spi_cs_n}, 32'd5, "idle cs levels");
    check("R9", {31'd0, spi_mosi}, 32'd1, "idle mosi level");
    burst(0, 3'b001, 1, 8, 32'h0000_0081, 32'h0000_00FF);
    check("R9", {29'd0, spi_cs_n}, 32'd5, "idle levels after burst");
    wr(5'h08, 32'h0007_0000);
    check("R9", {29'd0, spi_cs_n}, 32'd7, "idle restored");

    // R10: disabled engine
    wr(5'h00, 32'd0);
    r0 = rises;
    wr(5'h14, sword(3'b010, 1, 8));
    rd(5'h14, v); check("R10", {31'd0, v[31]}, 32'd0, "disabled start");
    repeat (20) @(negedge clk);
    check("R10", rises, r0, "no sclk when disabled");
    check("R10", {29'd0, spi_cs_n}, 32'd7, "cs idle when disabled");
    wr(5'h00, 32'd1);
    burst(0, 3'b010, 1, 8, 32'h0000_0042, 32'h0000_0024);

    repeat (3) @(negedge clk);
    summary();
  end
endmodule